// File: doc/BRIEF.md
# Sleep-Mode Power Control Register

This block holds the sleep-mode settings of a mixed-signal device and reports whether the device has been put into shutdown. A host reaches it through a serial interface whose framing logic sits outside the block. That logic hands over decoded strobes: a write or read of this register, the lowest bit of the address control byte, the data byte, an access to a separate dedicated sleep address, and a write to the normal-mode register address. The lowest address bit is a sleep command. A write that carries it at 1 sets the shutdown flag. The flag cannot be written through the data byte.

Three things clear the shutdown flag: a write to the normal-mode address, a day-alarm pulse, and a selected edge on an asynchronous wake-up pin. While the flag is set, or while the external sleep input is high, the device is asleep. In sleep, the effective enables for the 32 kHz oscillator, the clock-output buffer and the PWM come from the three sleep bits of this register. Out of sleep they come from the normal-mode enable inputs. The PWM can only run in sleep when the sleep oscillator bit is also set.

Top module: `sleep_pwr_reg`

## Requirements
- R1: After reset, a read returns 8'hC0 (sleep oscillator 1, sleep clock output 1, sleep PWM 0, shutdown 0). The shutdown output is 0 and the device is awake.
- R2: The read byte is {sleep_osc[7], sleep_clkout[6], sleep_pwm[5], shutdown[4], 4'b0000}. A write loads bits 7:5 from the data byte, and the new value is readable the cycle after the write. Data bits 4:0 of a write are ignored.
- R3: A write with the address command bit at 1 sets the shutdown flag one cycle later.
- R4: A write with the command bit at 0, or a read with the command bit at either value, leaves the shutdown flag unchanged.
- R5: An access strobe to the dedicated sleep address sets the shutdown flag one cycle later.
- R6: A normal-mode address write or a day-alarm pulse clears the shutdown flag one cycle later.
- R7: An edge on the wake pin in the polarity chosen by the edge-select input (1 = rising, 0 = falling) clears the shutdown flag at the third rising clock edge after the pin changes. An edge of the other polarity has no effect.
- R8: When a clear event and a set event occur in the same cycle, the clear wins and the flag ends at 0.
- R9: The sleep-active output is the OR of the shutdown flag and the external sleep input.
- R10: While sleep is active, the oscillator and clock-output enables equal their sleep bits. While awake, all three effective enables equal their normal-mode inputs.
- R11: While sleep is active, the PWM enable is the sleep PWM bit ANDed with the sleep oscillator bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous power-on reset |
| wr_en | input | 1 | Host write strobe for this register |
| rd_en | input | 1 | Host read strobe for this register |
| cmd_sleep | input | 1 | Lowest bit of the address control byte |
| wr_data | input | 8 | Write data byte |
| sleep_addr_hit | input | 1 | Access to the dedicated sleep address |
| norm_addr_wr | input | 1 | Write to the normal-mode register address |
| day_alarm | input | 1 | Day-alarm pulse, one cycle |
| wake_pin | input | 1 | Asynchronous wake-up pin |
| wake_edge_sel | input | 1 | Wake edge polarity: 1 rising, 0 falling |
| ext_sleep | input | 1 | External sleep request input |
| norm_osc_en | input | 1 | Normal-mode oscillator enable |
| norm_ck_en | input | 1 | Normal-mode clock-output enable |
| norm_pwm_en | input | 1 | Normal-mode PWM enable |
| rd_data | output | 8 | Register contents during a read, 0 otherwise |
| shdn | output | 1 | Shutdown flag |
| sleep_active | output | 1 | Device is in sleep |
| osc_en | output | 1 | Effective oscillator enable |
| ck_en | output | 1 | Effective clock-output enable |
| pwm_en | output | 1 | Effective PWM enable |

## Verification
Writes, set commands and clear strobes act one cycle later. The bench drives each stimulus at a falling edge and reads back at the next falling edge, after exactly one rising edge. A wake-pin edge needs three rising edges before the flag drops, so the bench checks the flag after the first and second edges (still set) and after the third (cleared). The effective enables and the sleep-active output are combinational from the flag and the inputs. They are sampled 1 ns after the inputs settle at a falling edge.

// File: rtl/sleep_pwr_reg.sv
module sleep_pwr_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       cmd_sleep,
  input  logic [7:0] wr_data,
  input  logic       sleep_addr_hit,
  input  logic       norm_addr_wr,
  input  logic       day_alarm,
  input  logic       wake_pin,
  input  logic       wake_edge_sel,
  input  logic       ext_sleep,
  input  logic       norm_osc_en,
  input  logic       norm_ck_en,
  input  logic       norm_pwm_en,
  output logic [7:0] rd_data,
  output logic       shdn,
  output logic       sleep_active,
  output logic       osc_en,
  output logic       ck_en,
  output logic       pwm_en
);
  logic       s_osc, s_ck, s_pwm;
  logic [2:0] wk_pipe;
  logic       wake_hit, set_req, clr_req;

  // wk_pipe[0], wk_pipe[1] synchronise the pin; wk_pipe[2] holds the previous value
  always_ff @(posedge clk) begin
    if (!rst_n) wk_pipe <= 3'b000;
    else        wk_pipe <= {wk_pipe[1:0], wake_pin};
  end

  assign wake_hit = wake_edge_sel ? (wk_pipe[1] & ~wk_pipe[2])
                                  : (~wk_pipe[1] & wk_pipe[2]);
  assign set_req  = (wr_en & cmd_sleep) | sleep_addr_hit;
  assign clr_req  = norm_addr_wr | day_alarm | wake_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_osc <= 1'b1;
      s_ck  <= 1'b1;
      s_pwm <= 1'b0;
      shdn  <= 1'b0;
    end else begin
      if (wr_en) {s_osc, s_ck, s_pwm} <= wr_data[7:5];
      if (clr_req)      shdn <= 1'b0;
      else if (set_req) shdn <= 1'b1;
    end
  end

  assign rd_data      = rd_en ? {s_osc, s_ck, s_pwm, shdn, 4'b0000} : 8'h00;
  assign sleep_active = shdn | ext_sleep;
  assign osc_en       = sleep_active ? s_osc           : norm_osc_en;
  assign ck_en        = sleep_active ? s_ck            : norm_ck_en;
  assign pwm_en       = sleep_active ? (s_pwm & s_osc) : norm_pwm_en;
endmodule

// File: rtl/sleep_pwr_reg_chk.sv
module sleep_pwr_reg_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic cmd_sleep,
  input logic sleep_addr_hit,
  input logic norm_addr_wr,
  input logic day_alarm,
  input logic wake_hit,
  input logic shdn,
  input logic sleep_active,
  input logic osc_en,
  input logic ck_en,
  input logic pwm_en,
  input logic norm_osc_en,
  input logic norm_ck_en,
  input logic norm_pwm_en
);
  logic any_clr;
  assign any_clr = norm_addr_wr | day_alarm | wake_hit;

  assert_cmd_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cmd_sleep && !any_clr) |=> shdn);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && cmd_sleep) && !sleep_addr_hit && !any_clr) |=> $stable(shdn));

  assert_addr_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_addr_hit && !any_clr) |=> shdn);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_addr_wr || day_alarm) |=> !shdn);

  assert_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_hit |=> !shdn);

  assert_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |-> sleep_active);

  assert_awake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_active |-> (osc_en == norm_osc_en && ck_en == norm_ck_en && pwm_en == norm_pwm_en));

  assert_pwm_osc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_active && pwm_en) |-> osc_en);
endmodule

bind sleep_pwr_reg sleep_pwr_reg_chk u_chk (.*);

// File: tb/sleep_pwr_reg_bench.sv
module sleep_pwr_reg_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, cmd_sleep = 0, sleep_addr_hit = 0, norm_addr_wr = 0, day_alarm = 0;
  logic wake_pin = 0, wake_edge_sel = 1, ext_sleep = 0;
  logic norm_osc_en = 0, norm_ck_en = 0, norm_pwm_en = 0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic shdn, sleep_active, osc_en, ck_en, pwm_en;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sleep_pwr_reg u_sleep_pwr_reg (.*);

  // {wr, rd, cmd, sah, nrm, alarm, data[7:0], expected read[7:0], req[3:0]}
  localparam int NV = 11;
  localparam logic [25:0] VEC [NV] = '{
    {6'b100000, 8'hA0, 8'hA0, 4'd2},  // R2 config write
    {6'b100000, 8'h3F, 8'h20, 4'd2},  // R2 bit4 and low bits ignored
    {6'b011000, 8'h00, 8'h20, 4'd4},  // R4 read with cmd=1
    {6'b101000, 8'hE0, 8'hF0, 4'd3},  // R3 write with cmd=1
    {6'b100000, 8'hC0, 8'hD0, 4'd4},  // R4 write cmd=0 keeps flag
    {6'b000010, 8'h00, 8'hC0, 4'd6},  // R6 normal-mode write
    {6'b000100, 8'h00, 8'hD0, 4'd5},  // R5 sleep address
    {6'b000001, 8'h00, 8'hC0, 4'd6},  // R6 day alarm
    {6'b101001, 8'hC0, 8'hC0, 4'd8},  // R8 set + alarm
    {6'b000110, 8'h00, 8'hC0, 4'd8},  // R8 sleep address + normal write
    {6'b010000, 8'h00, 8'hC0, 4'd4}   // R4 read with cmd=0
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; cmd_sleep = 0; sleep_addr_hit = 0;
    norm_addr_wr = 0; day_alarm = 0; wr_data = 8'h00;
  endtask

  task automatic read_chk(input string req, input logic [7:0] exp);
    rd_en = 1; #1;
    chk(req, rd_data, exp);
    rd_en = 0;
  endtask

  task automatic pulse_sah();
    @(negedge clk); sleep_addr_hit = 1;
    @(negedge clk); idle();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    read_chk("R1", 8'hC0);
    chk("R1", {5'b0, shdn, sleep_active, 1'b0}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {wr_en, rd_en, cmd_sleep, sleep_addr_hit, norm_addr_wr, day_alarm} = VEC[i][25:20];
      wr_data = VEC[i][19:12];
      @(negedge clk);
      idle();
      read_chk($sformatf("R%0d", VEC[i][3:0]), VEC[i][11:4]);
    end

    // R10 R11: config 0x60 (osc 0, clk-out 1, pwm 1), then sleep
    norm_osc_en = 1; norm_ck_en = 0; norm_pwm_en = 1;
    @(negedge clk); wr_en = 1; wr_data = 8'h60;
    @(negedge clk); idle(); #1;
    chk("R10", {5'b0, osc_en, ck_en, pwm_en}, 8'b101);
    pulse_sah(); #1;
    chk("R9", {7'b0, sleep_active}, 8'h01);
    chk("R11", {5'b0, osc_en, ck_en, pwm_en}, 8'b010);
    @(negedge clk); wr_en = 1; wr_data = 8'hA0;
    @(negedge clk); idle(); #1;
    chk("R10", {5'b0, osc_en, ck_en, pwm_en}, 8'b101);
    chk("R4", {7'b0, shdn}, 8'h01);
    @(negedge clk); norm_addr_wr = 1;
    @(negedge clk); idle(); norm_pwm_en = 0; #1;
    chk("R10", {4'b0, sleep_active, osc_en, ck_en, pwm_en}, 8'b0100);
    ext_sleep = 1; #1;
    chk("R9", {4'b0, sleep_active, osc_en, ck_en, pwm_en}, 8'b1101);
    ext_sleep = 0;

    // R7 rising edge selected
    wake_edge_sel = 1;
    pulse_sah();
    wake_pin = 1;
    @(negedge clk); chk("R7", {7'b0, shdn}, 8'h01);
    @(negedge clk); chk("R7", {7'b0, shdn}, 8'h01);
    @(negedge clk); chk("R7", {7'b0, shdn}, 8'h00);
    pulse_sah();
    wake_pin = 0;
    repeat (5) @(negedge clk);
    chk("R7", {7'b0, shdn}, 8'h01);
    // R7 falling edge selected
    wake_edge_sel = 0;
    wake_pin = 1;
    repeat (5) @(negedge clk);
    chk("R7", {7'b0, shdn}, 8'h01);
    wake_pin = 0;
    @(negedge clk); @(negedge clk);
    chk("R7", {7'b0, shdn}, 8'h01);
    @(negedge clk);
    chk("R7", {7'b0, shdn}, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule